// File: doc/BRIEF.md
# Shader Index Register Unit

This block keeps the three index registers that a programmable shader core uses for relative operand addressing. Two of them are address registers. A move-to-address operation loads them from the integer forms of the first two source components, and each has its own write enable. The third is the running loop counter. A loop-start strobe loads it from one packed 32-bit integer uniform. That same uniform also supplies the loop's iteration count and its per-iteration step.

An iteration-end strobe adds the step to the loop counter and uses up one iteration. A sticky done flag rises when the last iteration is consumed. A two-bit select picks the offset that relative addressing applies: zero, address register 0, address register 1, or the loop counter. Instruction decode, program-counter control and nesting of loops belong to the surrounding core.

Top module: `index_reg_unit`

## Requirements
- R1: A synchronous active-high reset clears both address registers, the loop counter, the remaining iteration count and the done flag to zero.
- R2: On a load strobe, mask bit 0 enables writing address register 0 from `ld_x`, and mask bit 1 enables writing address register 1 from `ld_y`. A register whose mask bit is 0, or any register when there is no strobe, keeps its value.
- R3: Address registers hold the full signed 32-bit value written, so negative values read back unchanged.
- R4: On a loop start, the loop counter becomes uniform bits [15:8], zero-extended to 32 bits. Bits [31:24] are ignored.
- R5: The iteration count is uniform bits [7:0] plus one. The done flag rises in the cycle after the iteration-end strobe that uses up the last iteration, and not earlier.
- R6: Each iteration-end strobe that has iterations remaining adds uniform bits [23:16], zero-extended, to the loop counter, modulo 2^32.
- R7: An iteration-end strobe when no iterations remain leaves the loop counter and the done flag unchanged.
- R8: When loop-start and iteration-end strobes occur in the same cycle, the loop start takes effect and no step is added.
- R9: The relative offset output equals 0 for select 0, address register 0 for select 1, address register 1 for select 2, and the loop counter for select 3. It follows the select within the same cycle.
- R10: A loop start clears the done flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | Move-to-address load strobe |
| ld_mask | input | 2 | Write enables: bit 0 for address reg 0, bit 1 for address reg 1 |
| ld_x | input | 32 | Signed value for address register 0 |
| ld_y | input | 32 | Signed value for address register 1 |
| loop_start | input | 1 | Loop-start strobe |
| loop_cfg | input | 32 | Packed uniform: [7:0] count-1, [15:8] start, [23:16] step |
| iter_end | input | 1 | Iteration-end strobe |
| rel_sel | input | 2 | Relative offset select (0 none, 1 addr0, 2 addr1, 3 loop counter) |
| addr0 | output | 32 | Address register 0 |
| addr1 | output | 32 | Address register 1 |
| loop_ctr | output | 32 | Loop counter register |
| loop_done | output | 1 | Iteration count exhausted |
| rel_off | output | 32 | Selected relative offset |

## Verification
The bench runs a loop whose counter starts at a nonzero value and counts strobes to the exact cycle that done rises. A design without the plus-one on the count would raise done one strobe early. The largest count byte gets a 256-iteration loop, which a count register one bit too narrow would wrap to zero. The bench also issues start and step in the same cycle, and a design with the wrong priority would show a counter one step too high. Partial load masks and extra iteration-end strobes after done catch designs that write a register whose enable is off or keep stepping after the count is spent. Negative address values catch a register narrowed or zero-extended on the way.

// File: rtl/index_pkg.sv
package index_pkg;
  localparam int DATA_W    = 32;
  localparam int FIELD_W   = 8;
  localparam int CNT_LSB   = 0;
  localparam int START_LSB = 8;
  localparam int STEP_LSB  = 16;
  localparam int CFG_W     = 4 * FIELD_W;
  localparam int NUM_ADDR  = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_A0   = 2'd1,
    SEL_A1   = 2'd2,
    SEL_LC   = 2'd3
  } rel_sel_e;
endpackage

// File: rtl/addr_reg_bank.sv
module addr_reg_bank #(
  parameter int DATA_W  = 32,
  parameter int NUM_REG = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ld_stb,
  input  logic [NUM_REG-1:0]          ld_mask,
  input  logic [NUM_REG*DATA_W-1:0]   ld_data,
  output logic [NUM_REG*DATA_W-1:0]   regs_q
);
  genvar g;
  generate
    for (g = 0; g < NUM_REG; g++) begin : g_reg
      logic [DATA_W-1:0] r_q;
      logic              wr;
      assign wr = ld_stb && ld_mask[g];

      always_ff @(posedge clk) begin
        if (rst)     r_q <= '0;
        else if (wr) r_q <= ld_data[g*DATA_W +: DATA_W];
      end
      assign regs_q[g*DATA_W +: DATA_W] = r_q;

      p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(ld_stb && ld_mask[g]) |=> $stable(regs_q[g*DATA_W +: DATA_W]))
        else $error("address register changed without enable");
      p_write_r3: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && ld_mask[g]) |=> regs_q[g*DATA_W +: DATA_W] == $past(ld_data[g*DATA_W +: DATA_W]))
        else $error("address register did not take written value");
    end
  endgenerate
endmodule

// File: rtl/loop_ctr_unit.sv
module loop_ctr_unit #(
  parameter int DATA_W    = 32,
  parameter int FIELD_W   = 8,
  parameter int CNT_LSB   = 0,
  parameter int START_LSB = 8,
  parameter int STEP_LSB  = 16,
  parameter int CFG_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CFG_W-1:0]  cfg,
  input  logic              step,
  output logic [DATA_W-1:0] ctr_q,
  output logic              done_q
);
  localparam int CNT_W = FIELD_W + 1;

  logic [FIELD_W-1:0] inc_q;
  logic [CNT_W-1:0]   rem_q;
  logic               live;

  assign live = (rem_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q  <= '0;
      inc_q  <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      ctr_q  <= DATA_W'(cfg[START_LSB +: FIELD_W]);
      inc_q  <= cfg[STEP_LSB +: FIELD_W];
      rem_q  <= CNT_W'(cfg[CNT_LSB +: FIELD_W]) + CNT_W'(1);
      done_q <= 1'b0;
    end else if (step && live) begin
      ctr_q <= ctr_q + DATA_W'(inc_q);
      rem_q <= rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) done_q <= 1'b1;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (ctr_q == '0 && !done_q))
    else $error("reset did not clear loop state");
  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> ctr_q == DATA_W'($past(cfg[START_LSB +: FIELD_W])))
    else $error("loop counter start value wrong");
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    start |=> !done_q)
    else $error("done not cleared by loop start");
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !live) |=> ($stable(ctr_q) && $stable(done_q)))
    else $error("counter moved with no iterations left");
  p_stepsum_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !start && live) |=> ctr_q == $past(ctr_q) + DATA_W'($past(inc_q)))
    else $error("counter step wrong");
  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> done_q)
    else $error("done dropped without loop start");
endmodule

// File: rtl/rel_off_mux.sv
module rel_off_mux
  import index_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] a0,
  input  logic [DATA_W-1:0] a1,
  input  logic [DATA_W-1:0] lc,
  output logic [DATA_W-1:0] off
);
  always_comb begin
    unique case (rel_sel_e'(sel))
      SEL_A0:  off = a0;
      SEL_A1:  off = a1;
      SEL_LC:  off = lc;
      default: off = '0;
    endcase
  end
endmodule

// File: rtl/index_reg_unit.sv
module index_reg_unit
  import index_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_stb,
  input  logic [1:0]        ld_mask,
  input  logic [31:0]       ld_x,
  input  logic [31:0]       ld_y,
  input  logic              loop_start,
  input  logic [31:0]       loop_cfg,
  input  logic              iter_end,
  input  logic [1:0]        rel_sel,
  output logic [31:0]       addr0,
  output logic [31:0]       addr1,
  output logic [31:0]       loop_ctr,
  output logic              loop_done,
  output logic [31:0]       rel_off
);
  logic [NUM_ADDR*DATA_W-1:0] bank_q;

  addr_reg_bank #(.DATA_W(DATA_W), .NUM_REG(NUM_ADDR)) u_bank (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_mask(ld_mask),
    .ld_data({ld_y, ld_x}), .regs_q(bank_q)
  );

  assign addr0 = bank_q[0 +: DATA_W];
  assign addr1 = bank_q[DATA_W +: DATA_W];

  loop_ctr_unit #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .CNT_LSB(CNT_LSB),
    .START_LSB(START_LSB), .STEP_LSB(STEP_LSB), .CFG_W(CFG_W)
  ) u_loop (
    .clk(clk), .rst(rst), .start(loop_start), .cfg(loop_cfg),
    .step(iter_end), .ctr_q(loop_ctr), .done_q(loop_done)
  );

  rel_off_mux #(.DATA_W(DATA_W)) u_mux (
    .sel(rel_sel), .a0(addr0), .a1(addr1), .lc(loop_ctr), .off(rel_off)
  );

  p_prio_r8: assert property (@(posedge clk) disable iff (rst)
    (loop_start && iter_end) |=> loop_ctr == DATA_W'($past(loop_cfg[START_LSB +: FIELD_W])))
    else $error("step applied on loop start cycle");
  p_sel_r9: assert property (@(posedge clk) disable iff (rst)
    (rel_sel == 2'd0) |-> rel_off == '0)
    else $error("offset not zero for select 0");
endmodule

// File: tb/test_index_reg_unit.sv
module test_index_reg_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic ld_stb = 0, loop_start = 0, iter_end = 0;
  logic [1:0] ld_mask = 0, rel_sel = 0;
  logic [31:0] ld_x = 0, ld_y = 0, loop_cfg = 0;
  logic [31:0] addr0, addr1, loop_ctr, rel_off;
  logic loop_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  index_reg_unit i_index_reg_unit (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_mask(ld_mask), .ld_x(ld_x),
    .ld_y(ld_y), .loop_start(loop_start), .loop_cfg(loop_cfg),
    .iter_end(iter_end), .rel_sel(rel_sel), .addr0(addr0), .addr1(addr1),
    .loop_ctr(loop_ctr), .loop_done(loop_done), .rel_off(rel_off)
  );

  typedef struct {
    logic [31:0] a0, a1, lc, off;
    logic        done;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  logic [31:0] m_a0 = 0, m_a1 = 0, m_lc = 0;
  logic [7:0]  m_inc = 0;
  int          m_rem = 0;
  logic        m_done = 0;

  task automatic cyc(input logic r, input logic ld, input logic [1:0] msk,
                     input logic [31:0] x, input logic [31:0] y,
                     input logic st, input logic [31:0] cfg,
                     input logic ie, input logic [1:0] sel, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; ld_stb = ld; ld_mask = msk; ld_x = x; ld_y = y;
    loop_start = st; loop_cfg = cfg; iter_end = ie; rel_sel = sel;
    if (r) begin
      m_a0 = 0; m_a1 = 0; m_lc = 0; m_inc = 0; m_rem = 0; m_done = 0;
    end else begin
      if (ld && msk[0]) m_a0 = x;
      if (ld && msk[1]) m_a1 = y;
      if (st) begin
        m_lc = {24'd0, cfg[15:8]}; m_inc = cfg[23:16];
        m_rem = int'(cfg[7:0]) + 1; m_done = 0;
      end else if (ie && m_rem > 0) begin
        m_lc = m_lc + {24'd0, m_inc};
        m_rem = m_rem - 1;
        if (m_rem == 0) m_done = 1;
      end
    end
    e.a0 = m_a0; e.a1 = m_a1; e.lc = m_lc; e.done = m_done; e.tag = tag;
    case (sel)
      2'd1: e.off = m_a0;
      2'd2: e.off = m_a1;
      2'd3: e.off = m_lc;
      default: e.off = 0;
    endcase
    sb.push_back(e);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "addr0", addr0, e.a0);
      chk(e.tag, "addr1", addr1, e.a1);
      chk(e.tag, "loop_ctr", loop_ctr, e.lc);
      chk(e.tag, "loop_done", {31'd0, loop_done}, {31'd0, e.done});
      chk(e.tag, "rel_off", rel_off, e.off);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    cyc(1, 0, 2'b00, 0, 0, 0, 0, 0, 2'd3, "R1");
    cyc(1, 1, 2'b11, 32'h55, 32'h66, 1, 32'h00FFFFFF, 1, 2'd1, "R1");
    // R2 and R3: full and partial loads, negative values
    cyc(0, 1, 2'b11, -32'sd5, 32'd1000, 0, 0, 0, 2'd1, "R3");
    cyc(0, 1, 2'b01, 32'd7, 32'd99, 0, 0, 0, 2'd2, "R2");
    cyc(0, 1, 2'b10, 32'd8, -32'sd129, 0, 0, 0, 2'd2, "R3");
    cyc(0, 1, 2'b00, 32'd1, 32'd2, 0, 0, 0, 2'd1, "R2");
    cyc(0, 0, 2'b11, 32'd3, 32'd4, 0, 0, 0, 2'd2, "R2");
    // R4 start value, high byte ignored; R9 select 3
    cyc(0, 0, 2'b00, 0, 0, 1, 32'hAA051002, 0, 2'd3, "R4");
    // R5 and R6: three iterations, done only after the last
    cyc(0, 0, 2'b00, 0, 0, 0, 0, 1, 2'd3, "R6");
    cyc(0, 0, 2'b00, 0, 0, 0, 0, 1, 2'd3, "R5");
    cyc(0, 0, 2'b00, 0, 0, 0, 0, 1, 2'd3, "R5");
    // R7 extra steps ignored
    cyc(0, 0, 2'b00, 0, 0, 0, 0, 1, 2'd3, "R7");
    cyc(0, 0, 2'b00, 0, 0, 0, 0, 1, 2'd0, "R9");
    // R8 start and step together; R10 done cleared
    cyc(0, 0, 2'b00, 0, 0, 1, 32'h00FFFF00, 1, 2'd3, "R8");
    cyc(0, 1, 2'b01, 32'h80000000, 0, 0, 0, 1, 2'd3, "R10");
    cyc(0, 0, 2'b00, 0, 0, 0, 0, 1, 2'd1, "R7");
    // R5 maximum count: 256 iterations
    cyc(0, 0, 2'b00, 0, 0, 1, 32'h000301FF, 0, 2'd3, "R4");
    for (int i = 0; i < 256; i++)
      cyc(0, 0, 2'b00, 0, 0, 0, 0, 1, 2'd3, "R5");
    cyc(0, 0, 2'b00, 0, 0, 0, 0, 1, 2'd3, "R7");
    // R10 restart after done
    cyc(0, 0, 2'b00, 0, 0, 1, 32'h00010400, 0, 2'd3, "R10");
    // R1 reset mid-loop
    cyc(1, 0, 2'b00, 0, 0, 0, 0, 1, 2'd2, "R1");
    cyc(0, 0, 2'b00, 0, 0, 0, 0, 1, 2'd3, "R7");
    @(negedge clk);
    ld_stb = 0; loop_start = 0; iter_end = 0;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule